// File: doc/BRIEF.md
# Fractional Root Clock Generator

This block produces one root clock from a set of up to eight source clocks. Each source arrives as a tick strobe, one per source half-cycle, all in the single fast clock domain. The ticks of the selected source feed a pre-divider. Its 5-bit field `v` divides by `(v+1)/2` when `v > 1`, so the divide ratio can be a whole or a half-integer value. Values 0 and 1 pass the source through undivided. An optional fractional stage follows. It takes a step once per pre-divided period and adds M to an accumulator modulo N. The output is high while the accumulator is below a duty threshold D.

Software writes a set of staged registers. Each write raises a dirty flag for the field it touched. New settings take effect only after the command register's update bit is set. That bit reads 1 until the new configuration is live and then clears itself, together with every dirty flag. While the root is running, the switch happens only at the end of an output period. While the root is off, the switch happens at once. A root-off status bit reports when neither the software enable nor the external request keeps the root alive.

Word addresses: 0 command, 1 configuration, 2 M, 3 inverted N−M, 4 inverted D. Reads return data one cycle after the address is presented.

Top module: `rcg_root`

## Requirements
- R1: After reset the command word reads 0x8000_0000 (root-off bit 31 set, everything else clear) and `clk_out` is low.
- R2: A write to configuration (word 1), M (word 2), N (word 3) or D (word 4) changes only the staged copy. It sets dirty bit 4, 5, 6 or 7 of the command word respectively and leaves the output waveform unchanged. The staged value reads back from its own word.
- R3: Writing 1 to command bit 0 makes that bit read 1 until the staged configuration is active. While the root is running, the switch happens only at an output-period boundary. Bit 0 and all dirty bits clear in the same cycle.
- R4: While the root is off, a requested update completes within two cycles, and the next time the root runs it uses the new configuration.
- R5: With the fractional stage bypassed, configuration bits 4:0 = v give an output period of 2 source ticks for v ≤ 1 and v+1 ticks otherwise. The output is high for the first ceil(period/2) ticks.
- R6: Configuration bits 10:8 select which `src_tick` bit clocks the pre-divider.
- R7: Configuration bits 13:12 = 2 together with a nonzero N word enable the fractional stage. The true N is (~N word + M) and the threshold is ~D word. With M = 1 the output period is N pre-divided periods, high for D of them.
- R8: With M > 1 and M ≤ D ≤ N−M, the output has exactly M rising edges in every N pre-divided periods.
- R9: A mode field other than 2, or an N word of zero, bypasses the fractional stage.
- R10: Command bit 31 reads 1 whenever command bit 1 and `ext_req` are both 0, and reads 0 within two cycles after either becomes 1. `clk_out` stays low while the root is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, at least twice the fastest source rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, one cycle after `addr` |
| src_tick | input | N_SRC | One strobe per half-cycle of each source clock |
| ext_req | input | 1 | Downstream enable request that keeps the root alive |
| clk_out | output | 1 | Generated root clock level |

## Verification
The divider path is exercised in several ways. Sources run at three different tick rates. Odd and even pre-divide fields are used, including the two pass-through codes. The fractional stage runs with M = 1 at two duty settings and with M = 2. Counting high cycles and rising edges over a whole number of periods separates a wrong divide ratio from a wrong duty or a wrong edge count. A zero N word and a non-dual mode under otherwise valid M/N/D values show whether the bypass decode is right. Directed tests then cover staging without update, the update handshake with its dirty flags, and an update committed while the root is off.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  typedef enum logic [2:0] {
    RA_CMD  = 3'd0,
    RA_CFG  = 3'd1,
    RA_MVAL = 3'd2,
    RA_NINV = 3'd3,
    RA_DINV = 3'd4
  } rcg_addr_e;

  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_EN_BIT    = 1;
  localparam int CMD_DIRTY_LSB = 4;
  localparam int CMD_OFF_BIT   = 31;

  localparam int CFG_DIV_LSB   = 0;
  localparam int CFG_DIV_W     = 5;
  localparam int CFG_SEL_LSB   = 8;
  localparam int CFG_MODE_LSB  = 12;
  localparam logic [1:0] MODE_DUAL = 2'd2;

  localparam int NUM_DIRTY = 4;

  // Pre-divider period in source ticks: codes 0 and 1 pass through.
  function automatic logic [CFG_DIV_W:0] prediv_period(input logic [CFG_DIV_W-1:0] v);
    return (v <= 5'd1) ? 6'd2 : ({1'b0, v} + 6'd1);
  endfunction

endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
  import rcg_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int MW    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic                 ext_req,
  input  logic                 commit,
  output logic                 root_off,
  output logic                 upd_pending,
  output logic [NUM_DIRTY-1:0] dirty,
  output logic                 root_en,
  output logic [SEL_W-1:0]     act_sel,
  output logic [CFG_DIV_W-1:0] act_div,
  output logic [1:0]           act_mode,
  output logic [MW-1:0]        act_m,
  output logic [MW-1:0]        act_ninv,
  output logic [MW-1:0]        act_dinv
);

  logic [SEL_W-1:0]     sh_sel;
  logic [CFG_DIV_W-1:0] sh_div;
  logic [1:0]           sh_mode;
  logic [MW-1:0]        sh_m, sh_ninv, sh_dinv;
  logic [31:0]          rd_next;

  always_comb begin
    rd_next = '0;
    case (addr)
      RA_CMD: begin
        rd_next[CMD_UPD_BIT]                      = upd_pending;
        rd_next[CMD_EN_BIT]                       = root_en;
        rd_next[CMD_DIRTY_LSB +: NUM_DIRTY]       = dirty;
        rd_next[CMD_OFF_BIT]                      = root_off;
      end
      RA_CFG: begin
        rd_next[CFG_DIV_LSB +: CFG_DIV_W] = sh_div;
        rd_next[CFG_SEL_LSB +: SEL_W]     = sh_sel;
        rd_next[CFG_MODE_LSB +: 2]        = sh_mode;
      end
      RA_MVAL: rd_next[MW-1:0] = sh_m;
      RA_NINV: rd_next[MW-1:0] = sh_ninv;
      RA_DINV: rd_next[MW-1:0] = sh_dinv;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      root_off    <= 1'b1;
      upd_pending <= 1'b0;
      dirty       <= '0;
      root_en     <= 1'b0;
      sh_sel      <= '0;
      sh_div      <= '0;
      sh_mode     <= '0;
      sh_m        <= '0;
      sh_ninv     <= '0;
      sh_dinv     <= '0;
      act_sel     <= '0;
      act_div     <= '0;
      act_mode    <= '0;
      act_m       <= '0;
      act_ninv    <= '0;
      act_dinv    <= '0;
    end else begin
      rdata    <= rd_next;
      root_off <= !(root_en || ext_req);
      if (commit) begin
        act_sel     <= sh_sel;
        act_div     <= sh_div;
        act_mode    <= sh_mode;
        act_m       <= sh_m;
        act_ninv    <= sh_ninv;
        act_dinv    <= sh_dinv;
        upd_pending <= 1'b0;
        dirty       <= '0;
      end
      if (wr_en) begin
        case (addr)
          RA_CMD: begin
            root_en <= wdata[CMD_EN_BIT];
            if (wdata[CMD_UPD_BIT]) upd_pending <= 1'b1;
          end
          RA_CFG: begin
            sh_div   <= wdata[CFG_DIV_LSB +: CFG_DIV_W];
            sh_sel   <= wdata[CFG_SEL_LSB +: SEL_W];
            sh_mode  <= wdata[CFG_MODE_LSB +: 2];
            dirty[0] <= 1'b1;
          end
          RA_MVAL: begin
            sh_m     <= wdata[MW-1:0];
            dirty[1] <= 1'b1;
          end
          RA_NINV: begin
            sh_ninv  <= wdata[MW-1:0];
            dirty[2] <= 1'b1;
          end
          RA_DINV: begin
            sh_dinv  <= wdata[MW-1:0];
            dirty[3] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rcg_prediv.sv
module rcg_prediv
  import rcg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 tick,
  input  logic [CFG_DIV_W-1:0] div,
  output logic                 last,
  output logic                 lvl_nx
);

  logic [CFG_DIV_W-1:0] pcnt, pcnt_nx;
  logic [CFG_DIV_W:0]   per, hi;

  always_comb begin
    per     = prediv_period(div);
    hi      = (per + 6'd1) >> 1;
    last    = tick && ({1'b0, pcnt} == per - 6'd1);
    pcnt_nx = pcnt;
    if (tick) pcnt_nx = last ? '0 : pcnt + 1'b1;
    lvl_nx  = ({1'b0, pcnt_nx} < hi);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pcnt <= '0;
    else            pcnt <= pcnt_nx;
  end

endmodule

// File: rtl/rcg_mnd.sv
module rcg_mnd #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [MW-1:0] m,
  input  logic [MW-1:0] ninv,
  input  logic [MW-1:0] dinv,
  output logic          wrap,
  output logic          lvl_nx
);

  logic [MW-1:0] acc, acc_nx, n_true, d_true;
  logic [MW:0]   sum;

  always_comb begin
    n_true = ~ninv + m;
    d_true = ~dinv;
    sum    = {1'b0, acc} + {1'b0, m};
    wrap   = step && (sum >= {1'b0, n_true});
    acc_nx = acc;
    if (step) begin
      if (wrap) acc_nx = sum[MW-1:0] - n_true;
      else      acc_nx = sum[MW-1:0];
    end
    lvl_nx = (acc_nx < d_true);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else            acc <= acc_nx;
  end

endmodule

// File: rtl/rcg_root.sv
module rcg_root
  import rcg_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int MW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [N_SRC-1:0] src_tick,
  input  logic             ext_req,
  output logic             clk_out
);

  localparam int SEL_W = $clog2(N_SRC);
  localparam int ACT_W = SEL_W + CFG_DIV_W + 2 + 3 * MW;

  logic                 root_off, upd_pending, root_en;
  logic [NUM_DIRTY-1:0] dirty;
  logic [SEL_W-1:0]     act_sel;
  logic [CFG_DIV_W-1:0] act_div;
  logic [1:0]           act_mode;
  logic [MW-1:0]        act_m, act_ninv, act_dinv;
  logic [ACT_W-1:0]     act_flat;
  logic                 tick, mnd_on, pd_last, pd_lvl, mnd_wrap, mnd_lvl;
  logic                 boundary, commit, clr;

  rcg_regs #(.SEL_W(SEL_W), .MW(MW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_req(ext_req), .commit(commit),
    .root_off(root_off), .upd_pending(upd_pending), .dirty(dirty),
    .root_en(root_en), .act_sel(act_sel), .act_div(act_div),
    .act_mode(act_mode), .act_m(act_m), .act_ninv(act_ninv),
    .act_dinv(act_dinv)
  );

  assign act_flat = {act_sel, act_div, act_mode, act_m, act_ninv, act_dinv};

  always_comb begin
    tick = 1'b0;
    if (!root_off && (int'(act_sel) < N_SRC)) tick = src_tick[act_sel];
  end

  assign mnd_on   = (act_mode == MODE_DUAL) && (act_ninv != '0);
  assign boundary = pd_last && (!mnd_on || mnd_wrap || (act_m == '0));
  assign commit   = upd_pending && (root_off || boundary);
  assign clr      = commit || root_off;

  rcg_prediv u_prediv (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .div(act_div),
    .last(pd_last), .lvl_nx(pd_lvl)
  );

  rcg_mnd #(.MW(MW)) u_mnd (
    .clk(clk), .rst(rst), .clr(clr), .step(pd_last && mnd_on),
    .m(act_m), .ninv(act_ninv), .dinv(act_dinv),
    .wrap(mnd_wrap), .lvl_nx(mnd_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst || root_off || commit) clk_out <= 1'b0;
    else if (tick)                 clk_out <= mnd_on ? mnd_lvl : pd_lvl;
  end

endmodule

// File: rtl/rcg_root_chk.sv
module rcg_root_chk #(
  parameter int ACT_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic             upd_pending,
  input logic             root_off,
  input logic             boundary,
  input logic             commit,
  input logic [3:0]       dirty,
  input logic [ACT_W-1:0] act_flat,
  input logic             clk_out
);

  // R1
  r1_reset_low_chk: assert property (@(posedge clk) $past(rst) |-> !clk_out);

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(commit) |-> $stable(act_flat));

  // R2
  dirty_mval_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2) |=> dirty[1]);

  // R3
  switch_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(upd_pending) && !$past(root_off)) |-> $past(boundary));

  // R3
  dirty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(upd_pending) && !$past(wr_en)) |-> (dirty == 4'd0));

  // R4
  off_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_pending && root_off && !wr_en) |=> !upd_pending);

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(root_off) |-> !clk_out);

endmodule

bind rcg_root rcg_root_chk #(.ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .upd_pending(upd_pending), .root_off(root_off), .boundary(boundary),
  .commit(commit), .dirty(dirty), .act_flat(act_flat), .clk_out(clk_out)
);

// File: tb/test_rcg_root.sv
`timescale 1ns/1ps
module test_rcg_root;

  localparam int N_SRC = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [N_SRC-1:0] src_tick = '0;
  logic             ext_req = 1'b0;
  logic             clk_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rcg_root #(.N_SRC(N_SRC), .MW(8)) i_rcg_root (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_tick(src_tick), .ext_req(ext_req), .clk_out(clk_out)
  );

  // Source i ticks once every i+1 reference cycles.
  initial begin
    forever begin
      @(negedge clk);
      cyc = cyc + 1;
      for (int i = 0; i < N_SRC; i++) src_tick[i] = ((cyc % (i + 1)) == 0);
    end
  end

  typedef struct packed {
    logic [31:0] cfg;
    logic [7:0]  m;
    logic [7:0]  n;
    logic [7:0]  d;
    int          per;
    int          hi;
    int          rise;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{32'h0000, 8'h00, 8'h00, 8'h00,  2,  1, 1},  // R5 code 0 passes through
    '{32'h0001, 8'h00, 8'h00, 8'h00,  2,  1, 1},  // R5 code 1 passes through
    '{32'h0004, 8'h00, 8'h00, 8'h00,  5,  3, 1},  // R5 divide by 2.5
    '{32'h0102, 8'h00, 8'h00, 8'h00,  6,  4, 1},  // R6 source 1, divide 1.5
    '{32'h0207, 8'h00, 8'h00, 8'h00, 24, 12, 1},  // R6 source 2, divide 4
    '{32'h2000, 8'h01, 8'hFC, 8'hFE,  8,  2, 1},  // R7 N=4 D=1
    '{32'h2003, 8'h01, 8'hFB, 8'hFD, 20,  8, 1},  // R7 div 2, N=5 D=2
    '{32'h2000, 8'h02, 8'hFC, 8'hFD, 10,  4, 2},  // R8 M=2 N=5 D=2
    '{32'h2004, 8'h01, 8'h00, 8'hFE,  5,  3, 1},  // R9 zero N word
    '{32'h1000, 8'h01, 8'hFC, 8'hFE,  2,  1, 1}   // R9 mode 1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1 v = rdata;
  endtask

  task automatic measure(input int n, output int hi, output int rise);
    logic prev, cur;
    hi = 0; rise = 0;
    @(negedge clk);
    prev = clk_out;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cur = clk_out;
      if (cur) hi++;
      if (cur && !prev) rise++;
      prev = cur;
    end
  endtask

  task automatic wait_clear(output logic [31:0] v);
    for (int k = 0; k < 300; k++) begin
      rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi, rise;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v);
    chk("R1 cmd after reset", v, 32'h8000_0000);
    chk("R1 clk_out after reset", {31'b0, clk_out}, 32'h0);

    // R10 off with no enable and no request
    measure(20, hi, rise);
    chk("R10 no edges while off", rise, 0);
    wr(3'd0, 32'h2);
    repeat (3) @(negedge clk);
    rd(3'd0, v);
    chk("R10 off clears after enable", v, 32'h0000_0002);

    // R2 staging without update
    wr(3'd1, 32'h0004);
    rd(3'd0, v);
    chk("R2 cfg dirty bit4", v, 32'h0000_0012);
    wr(3'd2, 32'h05);
    rd(3'd0, v);
    chk("R2 M dirty bit5", v, 32'h0000_0032);
    rd(3'd2, v);
    chk("R2 M readback", v, 32'h05);
    measure(16, hi, rise);
    chk("R2 output unchanged rises", rise, 8);
    wr(3'd3, 32'h00);
    wr(3'd4, 32'hFE);
    rd(3'd0, v);
    chk("R2 all dirty", v, 32'h0000_00F2);

    // R3 update handshake
    wr(3'd0, 32'h3);
    rd(3'd0, v);
    chk("R3 update bit reads 1", {31'b0, v[0]}, 32'h1);
    wait_clear(v);
    chk("R3 update and dirty clear together", v, 32'h0000_0002);

    // R5..R9 vector table
    foreach (VECS[i]) begin
      wr(3'd1, VECS[i].cfg);
      wr(3'd2, {24'b0, VECS[i].m});
      wr(3'd3, {24'b0, VECS[i].n});
      wr(3'd4, {24'b0, VECS[i].d});
      wr(3'd0, 32'h3);
      wait_clear(v);
      chk($sformatf("R3 vec%0d commit", i), v, 32'h0000_0002);
      repeat (3 * VECS[i].per + 8) @(negedge clk);
      measure(4 * VECS[i].per, hi, rise);
      chk($sformatf("R5-R9 vec%0d high cycles", i), hi, 4 * VECS[i].hi);
      chk($sformatf("R5-R9 vec%0d rising edges", i), rise, 4 * VECS[i].rise);
    end

    // R4 update while off
    wr(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    wr(3'd1, 32'h0001);
    wr(3'd0, 32'h1);
    rd(3'd0, v);
    rd(3'd0, v);
    chk("R4 off update done", v, 32'h8000_0000);
    measure(12, hi, rise);
    chk("R10 quiet while off", rise, 0);
    ext_req = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, v);
    chk("R10 request clears off", {31'b0, v[31]}, 32'h0);
    repeat (6) @(negedge clk);
    measure(16, hi, rise);
    chk("R4 new config after off", rise, 8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule